// File: doc/BRIEF.md
# Per-Block Locality Classifier

This block sits beside one cache block and decides at run time whether the data in that block behaves as "temporal" (the same words come back again and again) or "spatial" (accesses sweep across the block). Each hit to the block comes with one bit that says which half of the block was touched. A saturating signed counter moves up for upper-half hits and down for lower-half hits. A second counter measures a fixed period in hits.

At the end of every period the classifier looks at the signed counter. If it has been driven to either limit, the hits were heavily skewed toward one half, so the block is marked temporal. Otherwise it is marked spatial. The new mark is kept in one flip-flop, and both counters start again from zero. A change of mark raises a one-cycle pulse, which the surrounding cache uses to reallocate the block at its next eviction. When the block is replaced, the counters clear and the mark takes a starting value supplied by the cache.

Top module: `locality_tagger`

## Requirements
- R1: After synchronous reset, `tag_o` is 0 (spatial) and `retag_o` is 0.
- R2: The signed balance counter starts at zero. It moves +1 on a hit with `upper_half_i`=1 and −1 on a hit with `upper_half_i`=0.
- R3: Once the balance counter equals +SAT_LIMIT or −SAT_LIMIT, it holds that value in both directions until it is cleared.
- R4: Evaluation happens on every PERIOD-th hit counted since the last clear. The balance value used includes that hit's own step. `tag_o` becomes 1 (temporal) if the value is at ±SAT_LIMIT and 0 (spatial) otherwise. It is visible after the edge that registers that hit.
- R5: Both counters return to zero right after each evaluation, so the next period starts from a fresh balance.
- R6: `replace_i` clears both counters and loads `tag_o` from `init_tag_i`. It takes priority over a hit in the same cycle, and that hit is not counted.
- R7: `retag_o` is high for exactly one cycle after an evaluation that writes a tag different from the stored one. It stays low for an evaluation that writes the same tag, and for a replacement.
- R8: In a cycle with `hit_i`=0 and `replace_i`=0, no state changes, whatever value `upper_half_i` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | One hit to the watched block this cycle |
| upper_half_i | input | 1 | Half of the block touched: 1 upper, 0 lower |
| replace_i | input | 1 | Block is being replaced this cycle |
| init_tag_i | input | 1 | Tag loaded at replacement (0 spatial, 1 temporal) |
| tag_o | output | 1 | Stored locality tag (0 spatial, 1 temporal) |
| retag_o | output | 1 | One-cycle pulse when an evaluation changes the tag |

## Verification
The hardest case to reach is a balance counter that is pinned at a limit while hits in the opposite direction keep arriving. The ports only show the tag at period ends, so a counter that wrongly comes back off the limit gives the same final tag unless the pattern is arranged with care. The stimulus therefore saturates in the first half of a period and then spends the rest of the period pushing the other way. A non-sticky counter would end at zero and report spatial. The bench also places replacements mid-period and coincident with hits. It checks that the tag is still unchanged one hit before the expected evaluation, which exposes any counter left uncleared.

// File: rtl/locality_tagger_pkg.sv
package locality_tagger_pkg;
  typedef enum logic {
    LOC_SPATIAL  = 1'b0,
    LOC_TEMPORAL = 1'b1
  } loc_tag_e;
endpackage

// File: rtl/lt_balance_counter.sv
module lt_balance_counter #(
  parameter int SAT_LIMIT = 4,
  localparam int UDW = $clog2(SAT_LIMIT + 1) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic step_up,
  input  logic clear,
  output logic sat_next
);
  localparam logic signed [UDW-1:0] POS_LIM = UDW'(SAT_LIMIT);
  localparam logic signed [UDW-1:0] NEG_LIM = -POS_LIM;

  logic signed [UDW-1:0] bal_q;
  logic signed [UDW-1:0] bal_nxt;
  logic                  pinned;

  assign pinned = (bal_q == POS_LIM) || (bal_q == NEG_LIM);

  always_comb begin
    bal_nxt = bal_q;
    if (step_en && !pinned) begin
      if (step_up) bal_nxt = bal_q + 1'b1;
      else         bal_nxt = bal_q - 1'b1;
    end
  end

  assign sat_next = (bal_nxt == POS_LIM) || (bal_nxt == NEG_LIM);

  always_ff @(posedge clk) begin
    if (rst || clear) bal_q <= '0;
    else              bal_q <= bal_nxt;
  end

  p_sticky_limit_r3: assert property (@(posedge clk) disable iff (rst)
    (pinned && !clear) |=> $stable(bal_q));
  p_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    (bal_q <= POS_LIM) && (bal_q >= NEG_LIM));
endmodule

// File: rtl/lt_period_counter.sv
module lt_period_counter #(
  parameter int PERIOD = 8,
  localparam int PCW = $clog2(PERIOD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic wrap
);
  localparam logic [PCW-1:0] LAST = PCW'(PERIOD - 1);

  logic [PCW-1:0] cnt_q;

  assign wrap = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || wrap) cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + 1'b1;
  end

  p_period_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/lt_tag_store.sv
module lt_tag_store
  import locality_tagger_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load_init,
  input  loc_tag_e init_tag,
  input  logic     eval,
  input  loc_tag_e new_tag,
  output loc_tag_e tag_q,
  output logic     retag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q   <= LOC_SPATIAL;
      retag_q <= 1'b0;
    end else if (load_init) begin
      tag_q   <= init_tag;
      retag_q <= 1'b0;
    end else if (eval) begin
      tag_q   <= new_tag;
      retag_q <= (new_tag != tag_q);
    end else begin
      retag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/locality_tagger.sv
module locality_tagger
  import locality_tagger_pkg::*;
#(
  parameter int SAT_LIMIT = 4,
  parameter int PERIOD    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic upper_half_i,
  input  logic replace_i,
  input  logic init_tag_i,
  output logic tag_o,
  output logic retag_o
);
  logic     hit_live;
  logic     period_end;
  logic     eval;
  logic     skewed;
  loc_tag_e tag_cur;
  loc_tag_e tag_new;
  loc_tag_e tag_init;

  assign hit_live = hit_i && !replace_i;
  assign eval     = hit_live && period_end;
  assign tag_new  = skewed ? LOC_TEMPORAL : LOC_SPATIAL;
  assign tag_init = loc_tag_e'(init_tag_i);

  lt_balance_counter #(.SAT_LIMIT(SAT_LIMIT)) u_balance (
    .clk      (clk),
    .rst      (rst),
    .step_en  (hit_live),
    .step_up  (upper_half_i),
    .clear    (replace_i || eval),
    .sat_next (skewed)
  );

  lt_period_counter #(.PERIOD(PERIOD)) u_period (
    .clk   (clk),
    .rst   (rst),
    .tick  (hit_live),
    .clear (replace_i),
    .wrap  (period_end)
  );

  lt_tag_store u_tag (
    .clk       (clk),
    .rst       (rst),
    .load_init (replace_i),
    .init_tag  (tag_init),
    .eval      (eval),
    .new_tag   (tag_new),
    .tag_q     (tag_cur),
    .retag_q   (retag_o)
  );

  assign tag_o = tag_cur;

  p_retag_means_change_r7: assert property (@(posedge clk) disable iff (rst)
    retag_o |-> (tag_o != $past(tag_o)));
  p_replace_loads_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(replace_i) && !$past(rst)) |-> (tag_o == $past(init_tag_i) && !retag_o));
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(hit_i) && !$past(replace_i) && !$past(rst)) |-> ($stable(tag_o) && !retag_o));
endmodule

// File: tb/locality_tagger_bench.sv
module locality_tagger_bench;
  localparam int X = 4;
  localparam int Y = 8;

  logic clk = 1'b0;
  logic rst, hit_i, upper_half_i, replace_i, init_tag_i;
  logic tag_o, retag_o;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  int   m_bal, m_cnt;
  logic m_tag, m_retag;

  always #4 clk = ~clk;

  locality_tagger #(.SAT_LIMIT(X), .PERIOD(Y)) u_locality_tagger (
    .clk(clk), .rst(rst), .hit_i(hit_i), .upper_half_i(upper_half_i),
    .replace_i(replace_i), .init_tag_i(init_tag_i),
    .tag_o(tag_o), .retag_o(retag_o)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // reference model from R2..R8, applied once per clock
  task automatic model(input logic h, input logic up, input logic rp, input logic it);
    m_retag = 1'b0;
    if (rp) begin
      m_bal = 0; m_cnt = 0; m_tag = it;
    end else if (h) begin
      if (m_bal != X && m_bal != -X) m_bal = up ? m_bal + 1 : m_bal - 1;
      m_cnt++;
      if (m_cnt == Y) begin
        logic nt;
        nt = (m_bal == X || m_bal == -X);
        m_retag = (nt != m_tag);
        m_tag = nt;
        m_bal = 0; m_cnt = 0;
      end
    end
  endtask

  task automatic step(input logic h, input logic up, input logic rp, input logic it, input string req);
    @(negedge clk);
    hit_i = h; upper_half_i = up; replace_i = rp; init_tag_i = it;
    @(posedge clk);
    model(h, up, rp, it);
    #2;
    check(req, tag_o, m_tag, "tag_o");
    check(req, retag_o, m_retag, "retag_o");
  endtask

  task automatic hits(input int n, input logic up, input string req);
    for (int i = 0; i < n; i++) step(1'b1, up, 1'b0, 1'b0, req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; hit_i = 0; upper_half_i = 0; replace_i = 0; init_tag_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_bal = 0; m_cnt = 0; m_tag = 0; m_retag = 0;
    check("R1", tag_o, 1'b0, "tag after reset");
    check("R1", retag_o, 1'b0, "retag after reset");
  endtask

  // R3: pinned at +X, then four opposite hits must not move it
  task automatic t_sat_upper;
    hits(4, 1'b1, "R3");
    hits(3, 1'b0, "R3");
    check("R4", tag_o, 1'b0, "tag one hit before period end");
    hits(1, 1'b0, "R3");
    check("R3", tag_o, 1'b1, "temporal after sticky +X");
    check("R7", retag_o, 1'b1, "retag on spatial->temporal");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    check("R7", retag_o, 1'b0, "retag lasts one cycle");
  endtask

  // R2/R3: lower saturation, same tag so no pulse
  task automatic t_sat_lower;
    hits(4, 1'b0, "R2");
    hits(4, 1'b1, "R3");
    check("R3", tag_o, 1'b1, "temporal after sticky -X");
    check("R7", retag_o, 1'b0, "no retag when unchanged");
  endtask

  // R5: previous period was pinned; a fresh balance must end spatial
  task automatic t_clear_after_eval;
    hits(2, 1'b1, "R5");
    for (int i = 0; i < 3; i++) begin
      hits(1, 1'b0, "R5");
      hits(1, 1'b1, "R5");
    end
    check("R5", tag_o, 1'b0, "spatial in fresh period");
    check("R7", retag_o, 1'b1, "retag on temporal->spatial");
  endtask

  // R2: mild skew stays below the limit
  task automatic t_partial;
    hits(3, 1'b1, "R2");
    hits(5, 1'b0, "R2");
    check("R2", tag_o, 1'b0, "spatial at balance -2");
  endtask

  // R8: idle cycles with the half bit toggling change nothing
  task automatic t_idle;
    hits(3, 1'b1, "R8");
    for (int i = 0; i < 20; i++) step(1'b0, i[0], 1'b0, 1'b1, "R8");
    hits(1, 1'b1, "R8");
    hits(3, 1'b0, "R8");
    check("R8", tag_o, 1'b0, "no eval before 8th hit");
    hits(1, 1'b0, "R8");
    check("R8", tag_o, 1'b1, "eval at 8th hit across idle gap");
  endtask

  // R6: replacement mid-period clears the period count
  task automatic t_replace;
    hits(3, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
    check("R6", tag_o, 1'b0, "init tag loaded");
    check("R6", retag_o, 1'b0, "no retag on replace");
    hits(5, 1'b1, "R6");
    check("R6", tag_o, 1'b0, "no eval after 5 hits past replace");
    hits(3, 1'b0, "R6");
    check("R6", tag_o, 1'b1, "eval 8 hits after replace");
  endtask

  // R6: replace wins over a simultaneous hit
  task automatic t_priority;
    step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
    check("R6", tag_o, 1'b1, "init temporal loaded");
    for (int i = 0; i < 7; i++) step(1'b1, i[0], 1'b0, 1'b0, "R6");
    check("R6", tag_o, 1'b1, "coincident hit not counted");
    hits(1, 1'b1, "R4");
    check("R4", tag_o, 1'b0, "spatial at 8th counted hit");
    check("R7", retag_o, 1'b1, "retag after priority case");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sat_upper();
        t_sat_lower();
        t_clear_after_eval();
        t_partial();
        t_idle();
        t_replace();
        t_priority();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++; n_errors++;
          $display("FAIL watchdog: actual=timeout expected=finish");
        end
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule